// File: doc/BRIEF.md
# Operand Effective Address Decoder

This block turns the addressing information of the instruction being executed into the operand that the datapath needs. It takes the decoded addressing-mode code, the opcode byte, the program byte that follows the opcode, and the current contents of the two pointer registers X and Y. From these it produces three things:

- an 8-bit data-space address, or an immediate operand with a flag that marks it;
- a flag for instructions that carry no operand;
- the instruction length in bytes, which the fetch logic uses to advance the program counter.

Five modes are covered:

- Immediate: the operand is the next program byte.
- Direct: the next program byte is the full data address.
- Short direct: one of four working registers is chosen by opcode bits.
- Indirect: the pointer register named by an opcode bit supplies the address.
- Inherent: there is no operand.

The working registers sit at fixed data addresses starting at a base of 80h. X is at 80h and Y at 81h.

The decode is combinational. Its result is captured in an output register, so every output reflects the inputs sampled at the previous rising clock edge. Reset is asynchronous and active low.

Top module: `opnd_ea_decoder`

## Requirements
- R1: While reset is asserted and after it is released, until the first clock edge, all outputs are zero. This covers the address, immediate flag, immediate value, no-operand flag and length.
- R2: Mode code 3'd1 (immediate) sets the immediate flag, presents the following program byte as the immediate value, gives address 0 and length 2.
- R3: Mode code 3'd2 (direct) presents the following program byte as the address, clears the immediate flag and gives length 2.
- R4: Mode code 3'd3 (short direct) gives address 80h plus opcode bits [1:0] and length 1. All other opcode bits and the following program byte have no effect.
- R5: Mode code 3'd4 (indirect) with opcode bit 4 = 0 presents the content of X as the address, with length 1.
- R6: Mode code 3'd4 (indirect) with opcode bit 4 = 1 presents the content of Y as the address, with length 1.
- R7: Mode code 3'd0 (inherent) sets the no-operand flag and gives address 0, immediate value 0 and length 1.
- R8: The unused mode codes 3'd5, 3'd6 and 3'd7 are decoded exactly as inherent.
- R9: Each output reflects the inputs sampled at the previous rising clock edge. The outputs follow a new input set on every cycle with no gaps.
- R10: The immediate flag is set only in immediate mode, and the immediate value is zero in every other mode. The no-operand flag is set only in inherent or unused modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Addressing-mode code |
| opcode_i | input | 8 | Opcode byte of the current instruction |
| nxt_byte_i | input | 8 | Program byte that follows the opcode |
| x_reg_i | input | 8 | Current content of pointer register X |
| y_reg_i | input | 8 | Current content of pointer register Y |
| ea_o | output | 8 | Effective data-space address |
| imm_flag_o | output | 1 | High when the operand is an immediate value |
| imm_val_o | output | 8 | Immediate operand value |
| no_opnd_o | output | 1 | High when the instruction has no operand |
| len_o | output | 2 | Instruction length in bytes |

## Verification
The bench drives short-direct opcodes whose upper bits and following byte are filled with junk. A decoder that looked at the wrong bits would return an address outside 80h–83h. The indirect tests use X and Y values that differ from each other and change between instructions, so an inverted or stuck selection on opcode bit 4 returns the other register. The unused mode codes and a back-to-back stream that changes mode on every cycle catch two further faults: a decoder that leaves reserved codes undefined or leaks stale immediate values, and one that adds or drops a cycle of latency.

// File: rtl/ead_pkg.sv
package ead_pkg;

  localparam int EAD_DW    = 8;
  localparam int EAD_LEN_W = 2;
  localparam int EAD_NSEL  = 5;

  typedef enum logic [2:0] {
    AM_INH = 3'd0,
    AM_IMM = 3'd1,
    AM_DIR = 3'd2,
    AM_SHD = 3'd3,
    AM_IND = 3'd4
  } amode_e;

  // one-hot select positions
  localparam int SEL_INH = 0;
  localparam int SEL_IMM = 1;
  localparam int SEL_DIR = 2;
  localparam int SEL_SHD = 3;
  localparam int SEL_IND = 4;

  typedef struct packed {
    logic [EAD_DW-1:0]    ea;
    logic                 imm;
    logic [EAD_DW-1:0]    immv;
    logic                 none;
    logic [EAD_LEN_W-1:0] len;
  } dec_res_t;

  // working register address: base plus two-bit index from the opcode
  function automatic logic [EAD_DW-1:0] shd_addr(input logic [EAD_DW-1:0] base,
                                                 input logic [EAD_DW-1:0] op);
    logic [EAD_DW-1:0] idx;
    idx = op & EAD_DW'(3);
    return base + idx;
  endfunction

  // pointer choice: opcode bit 4 low picks X, high picks Y
  function automatic logic [EAD_DW-1:0] ind_addr(input logic [EAD_DW-1:0] op,
                                                 input logic [EAD_DW-1:0] x,
                                                 input logic [EAD_DW-1:0] y);
    return ((op >> 4) & EAD_DW'(1)) != '0 ? y : x;
  endfunction

  // bytes occupied by an instruction of the given mode
  function automatic logic [EAD_LEN_W-1:0] len_of(input logic two_byte);
    return two_byte ? EAD_LEN_W'(2) : EAD_LEN_W'(1);
  endfunction

endpackage

// File: rtl/ead_mode_dec.sv
module ead_mode_dec
  import ead_pkg::*;
#(
  parameter int NSEL = EAD_NSEL
) (
  input  logic [2:0]      mode_i,
  output logic [NSEL-1:0] sel_o
);

  logic known;

  always_comb begin
    sel_o = '0;
    known = 1'b1;
    unique case (mode_i)
      AM_IMM:  sel_o[SEL_IMM] = 1'b1;
      AM_DIR:  sel_o[SEL_DIR] = 1'b1;
      AM_SHD:  sel_o[SEL_SHD] = 1'b1;
      AM_IND:  sel_o[SEL_IND] = 1'b1;
      AM_INH:  sel_o[SEL_INH] = 1'b1;
      default: known = 1'b0;
    endcase
    // unused codes fold onto inherent (R8)
    if (!known) sel_o[SEL_INH] = 1'b1;
  end

  // R8: exactly one mode path is active for every code
  always_comb begin
    a_r8_sel_onehot: assert ($countones(sel_o) == 1);
  end

endmodule

// File: rtl/ead_len_calc.sv
module ead_len_calc
  import ead_pkg::*;
#(
  parameter int NSEL  = EAD_NSEL,
  parameter int LEN_W = EAD_LEN_W
) (
  input  logic [NSEL-1:0]  sel_i,
  output logic [LEN_W-1:0] len_o
);

  logic two_byte;

  assign two_byte = sel_i[SEL_IMM] | sel_i[SEL_DIR];
  assign len_o    = LEN_W'(len_of(two_byte));

endmodule

// File: rtl/ead_addr_sel.sv
module ead_addr_sel
  import ead_pkg::*;
#(
  parameter int          NSEL     = EAD_NSEL,
  parameter int          DW       = EAD_DW,
  parameter logic [DW-1:0] REG_BASE = 8'h80
) (
  input  logic [NSEL-1:0] sel_i,
  input  logic [DW-1:0]   opcode_i,
  input  logic [DW-1:0]   nxt_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [DW-1:0]   ea_o,
  output logic            imm_o,
  output logic [DW-1:0]   immv_o,
  output logic            none_o
);

  logic [DW-1:0] shd_ea;
  logic [DW-1:0] ind_ea;

  assign shd_ea = shd_addr(REG_BASE, opcode_i);
  assign ind_ea = ind_addr(opcode_i, x_i, y_i);

  always_comb begin
    ea_o   = '0;
    imm_o  = sel_i[SEL_IMM];
    immv_o = sel_i[SEL_IMM] ? nxt_i : '0;
    none_o = sel_i[SEL_INH];
    if (sel_i[SEL_DIR]) ea_o = nxt_i;
    if (sel_i[SEL_SHD]) ea_o = shd_ea;
    if (sel_i[SEL_IND]) ea_o = ind_ea;
  end

  // R4: short-direct addresses stay inside the four-register window
  always_comb begin
    if (sel_i[SEL_SHD])
      a_r4_shd_window: assert (shd_ea >= REG_BASE && shd_ea <= REG_BASE + DW'(3));
  end

endmodule

// File: rtl/opnd_ea_decoder.sv
module opnd_ea_decoder
  import ead_pkg::*;
#(
  parameter int            DW       = EAD_DW,
  parameter int            LEN_W    = EAD_LEN_W,
  parameter logic [DW-1:0] REG_BASE = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [DW-1:0]    opcode_i,
  input  logic [DW-1:0]    nxt_byte_i,
  input  logic [DW-1:0]    x_reg_i,
  input  logic [DW-1:0]    y_reg_i,
  output logic [DW-1:0]    ea_o,
  output logic             imm_flag_o,
  output logic [DW-1:0]    imm_val_o,
  output logic             no_opnd_o,
  output logic [LEN_W-1:0] len_o
);

  localparam int NSEL = EAD_NSEL;

  logic [NSEL-1:0]  mode_sel;
  logic [DW-1:0]    nxt_ea;
  logic             nxt_imm;
  logic [DW-1:0]    nxt_immv;
  logic             nxt_none;
  logic [LEN_W-1:0] nxt_len;
  logic             seen_q;   // an edge out of reset has loaded the outputs

  ead_mode_dec #(.NSEL(NSEL)) u_mode (
    .mode_i (mode_i),
    .sel_o  (mode_sel)
  );

  ead_addr_sel #(.NSEL(NSEL), .DW(DW), .REG_BASE(REG_BASE)) u_addr (
    .sel_i    (mode_sel),
    .opcode_i (opcode_i),
    .nxt_i    (nxt_byte_i),
    .x_i      (x_reg_i),
    .y_i      (y_reg_i),
    .ea_o     (nxt_ea),
    .imm_o    (nxt_imm),
    .immv_o   (nxt_immv),
    .none_o   (nxt_none)
  );

  ead_len_calc #(.NSEL(NSEL), .LEN_W(LEN_W)) u_len (
    .sel_i (mode_sel),
    .len_o (nxt_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_o       <= '0;
      imm_flag_o <= 1'b0;
      imm_val_o  <= '0;
      no_opnd_o  <= 1'b0;
      len_o      <= '0;
      seen_q     <= 1'b0;
    end else begin
      ea_o       <= nxt_ea;
      imm_flag_o <= nxt_imm;
      imm_val_o  <= nxt_immv;
      no_opnd_o  <= nxt_none;
      len_o      <= nxt_len;
      seen_q     <= 1'b1;
    end
  end

  // R1: outputs held at zero until the first loading edge
  a_r1_reset_zero: assert property (@(posedge clk)
    !seen_q |-> (ea_o == '0 && !imm_flag_o && imm_val_o == '0 && !no_opnd_o && len_o == '0));

  a_r2_imm_value: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) == AM_IMM) |->
      (imm_flag_o && imm_val_o == $past(nxt_byte_i) && len_o == LEN_W'(2)));

  a_r3_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) == AM_DIR) |->
      (ea_o == $past(nxt_byte_i) && len_o == LEN_W'(2) && !imm_flag_o));

  a_r4_short_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) == AM_SHD) |->
      (ea_o == REG_BASE + DW'($past(opcode_i[1:0])) && len_o == LEN_W'(1)));

  a_r5_ind_x: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) == AM_IND && !$past(opcode_i[4])) |->
      (ea_o == $past(x_reg_i) && len_o == LEN_W'(1)));

  a_r6_ind_y: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) == AM_IND && $past(opcode_i[4])) |->
      (ea_o == $past(y_reg_i) && len_o == LEN_W'(1)));

  a_r7_inherent: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(mode_i) == AM_INH || $past(mode_i) > 3'd4)) |->
      (no_opnd_o && len_o == LEN_W'(1) && ea_o == '0));

  a_r10_imm_only: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode_i) != AM_IMM) |-> (!imm_flag_o && imm_val_o == '0));

endmodule

// File: tb/test_opnd_ea_decoder.sv
module test_opnd_ea_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic [7:0] opcode_i = '0;
  logic [7:0] nxt_byte_i = '0;
  logic [7:0] x_reg_i = '0;
  logic [7:0] y_reg_i = '0;
  logic [7:0] ea_o;
  logic       imm_flag_o;
  logic [7:0] imm_val_o;
  logic       no_opnd_o;
  logic [1:0] len_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  opnd_ea_decoder i_opnd_ea_decoder (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .opcode_i(opcode_i),
    .nxt_byte_i(nxt_byte_i), .x_reg_i(x_reg_i), .y_reg_i(y_reg_i),
    .ea_o(ea_o), .imm_flag_o(imm_flag_o), .imm_val_o(imm_val_o),
    .no_opnd_o(no_opnd_o), .len_o(len_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected result, packed {ea, imm, immv, none, len}, worked out from the requirements
  function automatic logic [19:0] model(input logic [2:0] m, input logic [7:0] op,
                                        input logic [7:0] nb, input logic [7:0] x,
                                        input logic [7:0] y);
    case (m)
      3'd1: return {8'h00, 1'b1, nb, 1'b0, 2'd2};
      3'd2: return {nb, 1'b0, 8'h00, 1'b0, 2'd2};
      3'd3: return {8'h80 | {6'd0, op[1:0]}, 1'b0, 8'h00, 1'b0, 2'd1};
      3'd4: return {(op[4] ? y : x), 1'b0, 8'h00, 1'b0, 2'd1};
      default: return {8'h00, 1'b0, 8'h00, 1'b1, 2'd1};
    endcase
  endfunction

  task automatic drive(input logic [2:0] m, input logic [7:0] op, input logic [7:0] nb,
                       input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    mode_i = m; opcode_i = op; nxt_byte_i = nb; x_reg_i = x; y_reg_i = y;
  endtask

  task automatic check_all(input string tag, input logic [19:0] e);
    chk({tag, " ea"},   ea_o,       e[19:12]);
    chk({tag, " imm"},  imm_flag_o, e[11]);
    chk({tag, " immv"}, imm_val_o,  e[10:3]);
    chk({tag, " none"}, no_opnd_o,  e[2]);
    chk({tag, " len"},  len_o,      e[1:0]);
  endtask

  // one instruction: drive, wait one edge, then compare
  task automatic one(input string tag, input logic [2:0] m, input logic [7:0] op,
                     input logic [7:0] nb, input logic [7:0] x, input logic [7:0] y);
    drive(m, op, nb, x, y);
    @(negedge clk);
    check_all(tag, model(m, op, nb, x, y));
  endtask

  task automatic t_reset();
    drive(3'd1, 8'hFF, 8'hA5, 8'h11, 8'h22);
    @(negedge clk);
    check_all("R1 in reset", 20'h0);
    rst_n = 1'b1;
    #2;
    check_all("R1 after release", 20'h0);
  endtask

  task automatic t_immediate();
    one("R2 imm a5", 3'd1, 8'h12, 8'hA5, 8'h00, 8'h00);
    one("R2 imm 00", 3'd1, 8'hFF, 8'h00, 8'h33, 8'h44);
    one("R2 imm ff", 3'd1, 8'h00, 8'hFF, 8'h00, 8'h00);
  endtask

  task automatic t_direct();
    one("R3 dir 00", 3'd2, 8'h55, 8'h00, 8'h01, 8'h02);
    one("R3 dir 7f", 3'd2, 8'h10, 8'h7F, 8'h01, 8'h02);
    one("R3 dir ff", 3'd2, 8'hEE, 8'hFF, 8'h01, 8'h02);
  endtask

  task automatic t_short();
    for (int i = 0; i < 4; i++) begin
      one("R4 shd", 3'd3, {6'b101101, 2'(i)}, 8'h3C, 8'h99, 8'h66);
      one("R4 shd junk", 3'd3, {6'b010010, 2'(i)}, 8'hFF, 8'h00, 8'hFF);
    end
  endtask

  task automatic t_indirect();
    one("R5 ind x", 3'd4, 8'h00, 8'hAA, 8'h3C, 8'hC3);
    one("R5 ind x upper bits", 3'd4, 8'hEF, 8'hAA, 8'h91, 8'h19);
    one("R6 ind y", 3'd4, 8'h10, 8'hAA, 8'h3C, 8'hC3);
    one("R6 ind y low bits", 3'd4, 8'h13, 8'h55, 8'h91, 8'h19);
  endtask

  task automatic t_inherent();
    one("R7 inh", 3'd0, 8'h42, 8'hEE, 8'h10, 8'h20);
    one("R7 inh ff", 3'd0, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic t_reserved();
    for (int m = 5; m < 8; m++)
      one("R8 reserved", 3'(m), 8'h93, 8'h77, 8'h44, 8'h88);
  endtask

  // R9 and R10: a new instruction every cycle, mode changes each time
  task automatic t_stream();
    logic [19:0] exp;
    logic [2:0]  m;
    logic [7:0]  op, nb, x, y;
    for (int k = 0; k < 24; k++) begin
      m  = 3'(k % 8);
      op = 8'(k * 37 + 5);
      nb = 8'(k * 53 + 9);
      x  = 8'(k * 11 + 1);
      y  = 8'(k * 29 + 200);
      drive(m, op, nb, x, y);
      if (k > 0) check_all("R9 R10 stream", exp);
      exp = model(m, op, nb, x, y);
    end
    @(negedge clk);
    check_all("R9 R10 stream last", exp);
    // held inputs keep the same result
    @(negedge clk);
    check_all("R9 hold", exp);
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_direct();
    t_short();
    t_indirect();
    t_inherent();
    t_reserved();
    t_stream();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule